// File: doc/BRIEF.md
# Atomic Bit Test-and-Set Unit

This unit carries out a single-bit test-and-set on a 24-bit word. A command gives a bit index, a destination selector and an address. For a memory destination the unit reads the word over a simple request/ready memory bus. It copies the chosen bit into the carry flag and writes the word back with that bit forced to one. A lock output stays asserted across both accesses, so no other bus master can slip in between them. Shared-memory semaphores built on this unit therefore stay atomic.

Two other destinations are served without any bus traffic. The first is an internal 24-bit work register. The second is the status flag byte. Setting bit k of the status byte, for k from 0 to 7, raises one condition flag. The flag order is C, V, Z, N, U, E, L, S.

Commands use a valid/ready handshake. `cmd_ready` is high only while the unit is idle. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. While the unit is busy `cmd_ready` is low, and a waiting command must keep its fields steady until it is taken. The memory side does not use back-pressure in that sense. A request is a one-cycle pulse, and the unit then waits in a wait state until the memory answers with `mem_ready`. Read data must be valid in the cycle `mem_ready` is high.

Top module: `tas_unit`

## Requirements
- R1: After reset `cmd_ready` is 1, `mem_lock`, `mem_rd_req`, `mem_wr_req`, `done` and `illegal` are 0, and `cc_flags` and `work_reg` are all zeros. `cmd_ready` is low from the edge that accepts a memory command until the write completes.
- R2: A legal command with `cmd_dest` = 2'b00 (memory) makes exactly one read and then exactly one write, both at `cmd_addr`. The read request appears in the cycle after acceptance.
- R3: The written word equals the word read with bit `cmd_index` set to one. The write still takes place when that bit was already one.
- R4: For the memory and work-register destinations, `cc_flags[0]` (carry C) becomes the value the chosen bit had before the operation. `cc_flags[7:1]` are unchanged.
- R5: `mem_lock` is high from the cycle of the read request through the cycle of the write acknowledge. It is low in the cycle after the write acknowledge.
- R6: Each request is a one-cycle pulse. The unit leaves each wait state only on `mem_ready`, so a memory operation keeps `cmd_ready` low for 4 + (read wait cycles) + (write wait cycles) cycles.
- R7: `done` is a one-cycle pulse in the cycle after the write acknowledge. For register and status destinations it comes in the cycle after acceptance.
- R8: An index above 23 pulses `illegal` in the cycle after acceptance. In that case there is no bus access, no `done`, and no change to `cc_flags` or `work_reg`.
- R9: With `cmd_dest` = 2'b10 or 2'b11 (status), an index k from 0 to 7 sets `cc_flags[k]`, where bit 0 is C, 1 is V, 2 is Z, 3 is N, 4 is U, 5 is E, 6 is L and 7 is S. All other flags are left as they are. Indices 8 to 23 change no flag. No bus access is made.
- R10: With `cmd_dest` = 2'b01 (work register), the old value of `work_reg[cmd_index]` goes to C and that bit is then set. No bus access is made.
- R11: A read of 24'h000000 with index 0 writes back 24'h000001 and leaves C = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_index | input | 5 | Bit index to test and set |
| cmd_addr | input | ADDR_W (16) | Memory address of the destination word |
| cmd_dest | input | 2 | 00 memory, 01 work register, 1x status flags |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_wr_req | output | 1 | One-cycle write request |
| mem_addr | output | ADDR_W (16) | Bus address |
| mem_wdata | output | 24 | Write data |
| mem_rdata | input | 24 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory acknowledge for the pending access |
| mem_lock | output | 1 | Bus lock across the read-modify-write |
| done | output | 1 | Operation complete pulse |
| illegal | output | 1 | Out-of-range index pulse |
| cc_flags | output | 8 | Condition flags S L E U N Z V C (bit 7 to bit 0) |
| work_reg | output | 24 | Internal work register |

## Verification
The bound checker watches the bus protocol on every cycle. It checks that a read follows each accepted memory command, that each request is a single cycle with the lock held after it, and that the lock only falls together with a completion. It also checks that a memory completion changes no flag except carry, that an illegal index leaves the bus idle and the flags steady, and that a status command makes no bus access. Some properties need a memory model and a reference word, so only the bench scenarios can show them: the exact data written back, the carry value, the access counts, the cycle count for each wait length, and the status-flag and work-register contents.

// File: rtl/tas_pkg.sv
package tas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT
  } seq_state_t;

  localparam logic [1:0] DST_MEM  = 2'b00;
  localparam logic [1:0] DST_WREG = 2'b01;
  localparam int         CARRY_BIT = 0;
endpackage

// File: rtl/tas_bit_ops.sv
module tas_bit_ops #(
  parameter int WORD_W = 24,
  parameter int IDX_W  = 5
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [IDX_W-1:0]  idx,
  output logic              old_bit,
  output logic [WORD_W-1:0] word_set,
  output logic              idx_ok
);
  logic [WORD_W-1:0] sel;

  // one-hot decode of the index; out-of-range indices give an empty mask
  for (genvar g = 0; g < WORD_W; g++) begin : g_dec
    assign sel[g] = (idx == IDX_W'(g));
  end

  assign old_bit  = |(word_in & sel);
  assign word_set = word_in | sel;
  assign idx_ok   = |sel;
endmodule

// File: rtl/tas_seq.sv
module tas_seq
  import tas_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 24,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              idle,
  output logic              rd_req,
  output logic              wr_req,
  output logic              lock,
  output logic              finish,
  output logic              done_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [DATA_W-1:0] word_q
);
  seq_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (start) state_nx = ST_RD_REQ;
      ST_RD_REQ:  state_nx = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_ready) state_nx = ST_WR_REQ;
      ST_WR_REQ:  state_nx = ST_WR_WAIT;
      ST_WR_WAIT: if (mem_ready) state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      idx_q  <= '0;
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      state  <= state_nx;
      done_q <= finish;
      if (state == ST_IDLE && start) begin
        addr_q <= start_addr;
        idx_q  <= start_idx;
      end
      if (state == ST_RD_WAIT && mem_ready) word_q <= mem_rdata;
    end
  end

  assign idle   = (state == ST_IDLE);
  assign rd_req = (state == ST_RD_REQ);
  assign wr_req = (state == ST_WR_REQ);
  assign lock   = (state != ST_IDLE);
  assign finish = (state == ST_WR_WAIT) && mem_ready;
endmodule

// File: rtl/tas_cc_regs.sv
module tas_cc_regs
  import tas_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_fin,
  input  logic              mem_old,
  input  logic              wreg_op,
  input  logic              wreg_old,
  input  logic [DATA_W-1:0] wreg_next,
  input  logic              stat_op,
  input  logic [FLAG_W-1:0] stat_next,
  output logic [FLAG_W-1:0] flags,
  output logic [DATA_W-1:0] wreg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      wreg  <= '0;
    end else begin
      if (mem_fin) flags[CARRY_BIT] <= mem_old;
      if (wreg_op) begin
        flags[CARRY_BIT] <= wreg_old;
        wreg             <= wreg_next;
      end
      if (stat_op) flags <= stat_next;
    end
  end
endmodule

// File: rtl/tas_unit.sv
module tas_unit
  import tas_pkg::*;
#(
  parameter  int ADDR_W = 16,
  parameter  int DATA_W = 24,
  parameter  int FLAG_W = 8,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [1:0]        cmd_dest,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              mem_lock,
  output logic              done,
  output logic              illegal,
  output logic [FLAG_W-1:0] cc_flags,
  output logic [DATA_W-1:0] work_reg
);
  logic              accept, idx_legal;
  logic              start_mem, start_wreg, start_stat, start_bad;
  logic              seq_idle, seq_finish, seq_done;
  logic [IDX_W-1:0]  seq_idx;
  logic [DATA_W-1:0] seq_word, wreg_next, cmd_mask_unused;
  logic              mem_old, wreg_old, stat_old_unused, mem_ok_unused, stat_ok_unused;
  logic [FLAG_W-1:0] stat_next;
  logic              local_done_q, illegal_q;

  assign accept     = cmd_valid && cmd_ready;
  assign start_mem  = accept && idx_legal && (cmd_dest == DST_MEM);
  assign start_wreg = accept && idx_legal && (cmd_dest == DST_WREG);
  assign start_stat = accept && idx_legal && cmd_dest[1];
  assign start_bad  = accept && !idx_legal;

  tas_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start_mem), .start_addr(cmd_addr), .start_idx(cmd_index),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .idle(seq_idle), .rd_req(mem_rd_req), .wr_req(mem_wr_req),
    .lock(mem_lock), .finish(seq_finish), .done_q(seq_done),
    .addr_q(mem_addr), .idx_q(seq_idx), .word_q(seq_word)
  );

  // modify path for the word fetched from memory
  tas_bit_ops #(.WORD_W(DATA_W), .IDX_W(IDX_W)) u_mem_bits (
    .word_in(seq_word), .idx(seq_idx),
    .old_bit(mem_old), .word_set(mem_wdata), .idx_ok(mem_ok_unused)
  );

  // modify path for the work register; its range check qualifies every command
  tas_bit_ops #(.WORD_W(DATA_W), .IDX_W(IDX_W)) u_wreg_bits (
    .word_in(work_reg), .idx(cmd_index),
    .old_bit(wreg_old), .word_set(wreg_next), .idx_ok(idx_legal)
  );

  // status flag byte: indices beyond the flag width decode to an empty mask
  tas_bit_ops #(.WORD_W(FLAG_W), .IDX_W(IDX_W)) u_stat_bits (
    .word_in(cc_flags), .idx(cmd_index),
    .old_bit(stat_old_unused), .word_set(stat_next), .idx_ok(stat_ok_unused)
  );

  assign cmd_mask_unused = '0;

  tas_cc_regs #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .mem_fin(seq_finish), .mem_old(mem_old),
    .wreg_op(start_wreg), .wreg_old(wreg_old), .wreg_next(wreg_next),
    .stat_op(start_stat), .stat_next(stat_next),
    .flags(cc_flags), .wreg(work_reg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      local_done_q <= 1'b0;
      illegal_q    <= 1'b0;
    end else begin
      local_done_q <= start_wreg || start_stat;
      illegal_q    <= start_bad;
    end
  end

  assign cmd_ready = seq_idle;
  assign done      = seq_done || local_done_q;
  assign illegal   = illegal_q;
endmodule

// File: rtl/tas_unit_checks.sv
module tas_unit_checks #(
  parameter int DATA_W = 24,
  parameter int FLAG_W = 8,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [IDX_W-1:0]  cmd_index,
  input logic [1:0]        cmd_dest,
  input logic              mem_rd_req,
  input logic              mem_wr_req,
  input logic              mem_ready,
  input logic              mem_lock,
  input logic              done,
  input logic              illegal,
  input logic [FLAG_W-1:0] cc_flags
);
  p_accept_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_dest == 2'b00 && int'(cmd_index) < DATA_W) |=> mem_rd_req);

  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> (!mem_rd_req && mem_lock));

  p_wr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |=> (!mem_wr_req && mem_lock));

  p_lock_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_lock) |-> (done && $past(mem_ready)));

  p_carry_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mem_lock)) |-> (cc_flags[FLAG_W-1:1] == $past(cc_flags[FLAG_W-1:1])));

  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && !mem_lock && $stable(cc_flags)));

  p_stat_no_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_dest[1]) |=> !mem_lock);
endmodule

bind tas_unit tas_unit_checks #(.DATA_W(DATA_W), .FLAG_W(FLAG_W), .IDX_W(IDX_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_index(cmd_index), .cmd_dest(cmd_dest), .mem_rd_req(mem_rd_req),
  .mem_wr_req(mem_wr_req), .mem_ready(mem_ready), .mem_lock(mem_lock),
  .done(done), .illegal(illegal), .cc_flags(cc_flags)
);

// File: tb/tas_unit_test.sv
module tas_unit_test;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 24;
  localparam int FLAG_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [4:0]        cmd_index = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [1:0]        cmd_dest = '0;
  logic              mem_rd_req, mem_wr_req, mem_lock, done, illegal;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic              mem_ready = 1'b0;
  logic [FLAG_W-1:0] cc_flags;
  logic [DATA_W-1:0] work_reg;

  always #10 clk = ~clk;

  tas_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_index(cmd_index), .cmd_addr(cmd_addr), .cmd_dest(cmd_dest),
    .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .mem_lock(mem_lock), .done(done), .illegal(illegal),
    .cc_flags(cc_flags), .work_reg(work_reg)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DATA_W-1:0] mem [16];
  int rd_cnt, wr_cnt, delay;
  logic [ADDR_W-1:0] rd_addr_seen, wr_addr_seen;
  bit pend, pend_wr;
  int pend_cnt;
  logic [3:0] pend_a;
  logic [DATA_W-1:0] pend_d;

  // memory model: answers each request after 'delay' wait cycles
  always @(negedge clk) begin
    mem_ready = 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_ready = 1'b1;
        if (pend_wr) mem[pend_a] = pend_d;
        else mem_rdata = mem[pend_a];
        pend = 0;
      end else pend_cnt--;
    end else if (rst_n && (mem_rd_req || mem_wr_req)) begin
      pend = 1; pend_wr = mem_wr_req; pend_cnt = delay;
      pend_a = mem_addr[3:0]; pend_d = mem_wdata;
      if (mem_wr_req) begin wr_cnt++; wr_addr_seen = mem_addr; end
      else begin rd_cnt++; rd_addr_seen = mem_addr; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int busy, gap, wait_t;
  bit saw_done, saw_ill, lock_at_end, done_after;

  task automatic do_op(input logic [1:0] dest, input int idx, input int addr);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; busy = 0; gap = 0; wait_t = 0;
    cmd_valid = 1'b1; cmd_dest = dest; cmd_index = 5'(idx); cmd_addr = ADDR_W'(addr);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done && !illegal && wait_t < 100) begin
      if (!cmd_ready) busy++;
      if (!mem_lock) gap++;
      wait_t++;
      @(negedge clk);
    end
    saw_done = done; saw_ill = illegal; lock_at_end = mem_lock;
    @(negedge clk);
    done_after = done;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] w, expw;
    logic [FLAG_W-1:0] expf, upper;
    logic [DATA_W-1:0] wmodel;
    int idx, a;
    bit oldb;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    delay = 0; pend = 0; rd_cnt = 0; wr_cnt = 0;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(cmd_ready == 1'b1 && mem_lock == 1'b0 && !mem_rd_req && !mem_wr_req && !done && !illegal,
        "R1 reset outputs", {cmd_ready, mem_lock, mem_rd_req, mem_wr_req, done, illegal}, 6'b100000);
    chk(cc_flags == '0 && work_reg == '0, "R1 reset registers", {cc_flags, work_reg}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: zero word, index 0
    mem[0] = 24'h000000;
    do_op(2'b00, 0, 0);
    chk(mem[0] == 24'h000001, "R11 written word", mem[0], 24'h000001);
    chk(cc_flags[0] == 1'b0, "R11 carry", cc_flags[0], 0);

    // preset two flags via the status path so carry-only updates can be seen
    do_op(2'b10, 2, 0);
    do_op(2'b11, 5, 0);
    upper = 8'h24;
    chk(cc_flags == 8'h24, "R9 preset flags", cc_flags, 8'h24);

    // memory sweep: every index, four patterns, three wait lengths
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < DATA_W; i++) begin
        case (p)
          0: w = 24'h000000;
          1: w = 24'hFFFFFF;
          2: w = 24'h5A5A5A ^ DATA_W'(i * 24'h010203);
          default: w = DATA_W'(32'h9E3779B9 >> i) ^ (24'h1 << i);
        endcase
        a = (i + p) % 16;
        mem[a] = w;
        delay = (i + p) % 3;
        do_op(2'b00, i, a + 16'h0140 * 0);
        expw = w | (DATA_W'(1) << i);
        oldb = w[i];
        chk(mem[a] == expw, "R3 write-back word", mem[a], expw);
        chk(cc_flags[0] == oldb, "R4 carry old bit", cc_flags[0], oldb);
        chk(cc_flags[7:1] == upper[7:1], "R4 other flags", cc_flags[7:1], upper[7:1]);
        chk(rd_cnt == 1 && wr_cnt == 1 && rd_addr_seen == ADDR_W'(a) && wr_addr_seen == ADDR_W'(a),
            "R2 access count/address", {rd_cnt[7:0], wr_cnt[7:0]}, 16'h0101);
        chk(gap == 0 && lock_at_end == 1'b0, "R5 lock window", {gap[7:0], 7'd0, lock_at_end}, 0);
        chk(busy == 4 + 2 * delay, "R6 busy cycles", busy, 4 + 2 * delay);
        chk(saw_done && !done_after, "R7 done pulse", {saw_done, done_after}, 2'b10);
      end
    end
    delay = 0;

    // R8: illegal indices on every destination
    for (int i = DATA_W; i < 32; i++) begin
      expf = cc_flags; wmodel = work_reg; w = mem[3];
      do_op(2'((i % 3 == 2) ? 2 : i % 3), i, 3);
      chk(saw_ill && !saw_done && !done_after, "R8 illegal pulse", {saw_ill, saw_done}, 2'b10);
      chk(rd_cnt == 0 && wr_cnt == 0 && mem[3] == w, "R8 no bus access", rd_cnt + wr_cnt, 0);
      chk(cc_flags == expf && work_reg == wmodel, "R8 state unchanged", cc_flags, expf);
    end

    // R9: status sweep from reset
    do_reset();
    expf = '0;
    for (int i = 0; i < DATA_W; i++) begin
      idx = (i * 5) % DATA_W;
      do_op((i % 2) ? 2'b11 : 2'b10, idx, 0);
      if (idx < FLAG_W) expf[idx] = 1'b1;
      chk(cc_flags == expf, "R9 status flags", cc_flags, expf);
      chk(rd_cnt == 0 && wr_cnt == 0 && saw_done, "R9 no bus access", rd_cnt + wr_cnt, 0);
    end

    // R10: work register sweep, every index visited twice
    do_reset();
    wmodel = '0;
    for (int i = 0; i < 2 * DATA_W; i++) begin
      idx = (i * 7) % DATA_W;
      oldb = wmodel[idx];
      do_op(2'b01, idx, 0);
      wmodel[idx] = 1'b1;
      chk(work_reg == wmodel, "R10 work register", work_reg, wmodel);
      chk(cc_flags == {7'd0, oldb}, "R10 carry", cc_flags, {7'd0, oldb});
      chk(rd_cnt == 0 && wr_cnt == 0 && saw_done, "R10 no bus access", rd_cnt + wr_cnt, 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule